// File: doc/BRIEF.md
# Demand-Driven Crossing Light Controller

This block runs the green and red lights at a crossing of a north-south road and an east-west road. Each road has a roadbed detector that reports whether a car is waiting. Each road has one light output: high means green and low means red. Exactly one road is green at any time.

The controller makes a decision only at a fixed interval. An internal counter divides the system clock down to that interval, and the default interval is thirty seconds. At each decision point, green passes to the other road only if a car is waiting on that road. Otherwise green stays where it is. If both roads report cars, green therefore alternates every interval. Between decision points, the detector inputs have no effect.

The block has no data stream, so all of its pins are plain control pins with no valid/ready handshake.

Top module: `xing_light_ctrl`

## Requirements
- R1: A synchronous active-high `rst` gives north-south green (`ns_go`=1, `ew_go`=0) and restarts the interval. The first decision after reset is released happens on the DWELL_CLKS-th rising clock edge after release.
- R2: At a decision point with north-south green and `ew_wait`=1, the next state is east-west green.
- R3: At a decision point with north-south green and `ew_wait`=0, north-south green stays, whatever `ns_wait` is.
- R4: At a decision point with east-west green and `ns_wait`=1, the next state is north-south green.
- R5: At a decision point with east-west green and `ns_wait`=0, east-west green stays, whatever `ew_wait` is.
- R6: Decisions happen only on every DWELL_CLKS-th rising edge, where DWELL_CLKS = CLK_HZ*DWELL_SEC. Detector values at any other edge are ignored, so a car that arrives and leaves between decision points causes no change.
- R7: If both detectors are high at every decision point, the green road alternates at each decision point.
- R8: The outputs depend only on the one-bit state (0 = north-south green, 1 = east-west green). `ns_go` is high only in state 0 and `ew_go` only in state 1, so the two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ns_wait | input | 1 | Car present on the north-south detector |
| ew_wait | input | 1 | Car present on the east-west detector |
| ns_go | output | 1 | North-south light: 1 = green, 0 = red |
| ew_go | output | 1 | East-west light: 1 = green, 0 = red |

## Verification
The patterns are:
- No cars at all.
- A car on the road that already has green only, which must not cause a switch.
- A car on the other road only, which must cause a switch.
- Cars on both roads, which must cause alternation.

Together these separate the four transitions of the state machine. One case has a car that appears on the other road and then leaves before the decision edge. This shows that only the value at the decision edge counts. Another case raises the request early and samples one clock before the decision, which catches any early switch. A reset in the middle of an interval, followed by a request, checks that the interval restarts from zero.

// File: rtl/xing_pkg.sv
package xing_pkg;
  typedef enum logic {
    PH_NS = 1'b0,
    PH_EW = 1'b1
  } phase_t;
endpackage

// File: rtl/xing_tick_gen.sv
module xing_tick_gen #(
  parameter int unsigned PERIOD = 30000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  // R6: the count never leaves its range, so the decision enable stays periodic
  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R6: the enable lasts a single cycle
  assert_tick_single_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/xing_phase_fsm.sv
module xing_phase_fsm
  import xing_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic ns_wait,
  input  logic ew_wait,
  output logic ns_go,
  output logic ew_go
);
  phase_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step) begin
      unique case (state_q)
        PH_NS: if (ew_wait) state_d = PH_EW;
        PH_EW: if (ns_wait) state_d = PH_NS;
        default: state_d = PH_NS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PH_NS;
    else     state_q <= state_d;
  end

  assign ns_go = (state_q == PH_NS);
  assign ew_go = (state_q == PH_EW);

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(state_q));

  assert_ns_to_ew_R2: assert property (@(posedge clk) disable iff (rst)
    (step && state_q == PH_NS && ew_wait) |=> state_q == PH_EW);

  assert_ns_stay_R3: assert property (@(posedge clk) disable iff (rst)
    (step && state_q == PH_NS && !ew_wait) |=> state_q == PH_NS);

  assert_ew_to_ns_R4: assert property (@(posedge clk) disable iff (rst)
    (step && state_q == PH_EW && ns_wait) |=> state_q == PH_NS);

  assert_ew_stay_R5: assert property (@(posedge clk) disable iff (rst)
    (step && state_q == PH_EW && !ns_wait) |=> state_q == PH_EW);
endmodule

// File: rtl/xing_light_ctrl.sv
module xing_light_ctrl #(
  parameter int unsigned CLK_HZ    = 1000,
  parameter int unsigned DWELL_SEC = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic ns_wait,
  input  logic ew_wait,
  output logic ns_go,
  output logic ew_go
);
  localparam int unsigned DWELL_CLKS = CLK_HZ * DWELL_SEC;

  logic step;

  xing_tick_gen #(.PERIOD(DWELL_CLKS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (step)
  );

  xing_phase_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .ns_wait (ns_wait),
    .ew_wait (ew_wait),
    .ns_go   (ns_go),
    .ew_go   (ew_go)
  );

  // R8: outside the decision edge the two lights keep their values
  assert_lights_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(ns_go) && $stable(ew_go)));
endmodule

// File: tb/xing_light_ctrl_test.sv
module xing_light_ctrl_test;
  localparam int unsigned HZ  = 4;
  localparam int unsigned SEC = 2;
  localparam int unsigned N   = HZ * SEC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ns_wait = 1'b0;
  logic ew_wait = 1'b0;
  logic ns_go, ew_go;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  xing_light_ctrl #(.CLK_HZ(HZ), .DWELL_SEC(SEC)) uut (
    .clk(clk), .rst(rst), .ns_wait(ns_wait), .ew_wait(ew_wait),
    .ns_go(ns_go), .ew_go(ew_go)
  );

  task automatic chk(input string tag, input logic [1:0] exp);
    checks++;
    if ({ns_go, ew_go} !== exp) begin
      fails++;
      $display("FAIL %s: lights {ns,ew} = %b, expected %b", tag, {ns_go, ew_go}, exp);
    end
  endtask

  // R8: never both green, checked every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (ns_go && ew_go) begin
        fails++;
        $display("FAIL R8: lights {ns,ew} = %b, expected one-hot", {ns_go, ew_go});
      end
    end
  end

  // One full interval with the given detector values; checks the outcome.
  task automatic interval(input logic ns, input logic ew, input string tag, input logic [1:0] exp);
    ns_wait = ns; ew_wait = ew;
    repeat (N) @(posedge clk);
    @(negedge clk);
    chk(tag, exp);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset", 2'b10);
    rst = 1'b0;
  endtask

  task automatic t_idle;
    interval(1'b0, 1'b0, "R3 idle stays NS", 2'b10);
    interval(1'b1, 1'b0, "R3 own car stays NS", 2'b10);
  endtask

  task automatic t_switch_to_ew;
    ns_wait = 1'b0; ew_wait = 1'b1;
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    chk("R6 no early switch", 2'b10);
    @(posedge clk); @(negedge clk);
    chk("R2 switch to EW", 2'b01);
  endtask

  task automatic t_ew_side;
    interval(1'b0, 1'b1, "R5 own car stays EW", 2'b01);
    interval(1'b0, 1'b0, "R5 idle stays EW", 2'b01);
    interval(1'b1, 1'b0, "R4 switch to NS", 2'b10);
  endtask

  task automatic t_glitch;
    ns_wait = 1'b0; ew_wait = 1'b1;
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    ew_wait = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 car gone before decision", 2'b10);
  endtask

  task automatic t_both;
    interval(1'b1, 1'b1, "R7 both -> EW", 2'b01);
    interval(1'b1, 1'b1, "R7 both -> NS", 2'b10);
    interval(1'b1, 1'b1, "R7 both -> EW again", 2'b01);
  endtask

  task automatic t_reset_mid;
    ns_wait = 1'b0; ew_wait = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset mid-interval", 2'b10);
    rst = 1'b0;
    ew_wait = 1'b1;
    repeat (N - 1) @(posedge clk);
    @(negedge clk);
    chk("R1 interval restarted", 2'b10);
    @(posedge clk); @(negedge clk);
    chk("R1 first decision after reset", 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_idle();
    t_switch_to_ew();
    t_ew_side();
    t_glitch();
    t_both();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule